// File: doc/BRIEF.md
# Framed Payload Serial/Nibble Output Interface

This block takes a received bit stream whose frame alignment is already known and hands it to system-side equipment. Every incoming bit arrives with a one-cycle valid strobe. A frame-sync marker accompanies the first bit of each frame. The block keeps its own count of the position within the frame. It classifies each bit as overhead or payload from a map chosen by the line type. It then presents the data in one of three output forms:

- a serial line with a flag that marks overhead bits;
- a serial line with a clock that is gapped, so it pulses only for payload bits;
- a four-bit nibble bus with a nibble-rate clock.

All logic runs on one internal clock at twice the bit rate. The caller raises the valid strobe at most once every two cycles. Each output clock is a registered pulse: high for the internal cycle after a bit (or nibble) is taken and low afterwards. Downstream logic therefore samples data on the falling edge of that pulse.

A new mode or line type is adopted only on a bit that carries the frame-sync marker. The frame in progress keeps the settings it started with.

Top module: `fpo_payload_out`

## Requirements
- R1: After reset every output is low. Until the first bit with `in_fsync` high is taken, valid bits produce no activity on any output.
- R2: In modes 2'b00 and 2'b01, a bit taken at a clock edge appears on `ser_out` from that edge. `oclk_out` is high for exactly that one cycle and low in the following cycle. Mode 2'b11 behaves exactly as 2'b00.
- R3: In mode 2'b00, `ohgc_out` is high for the whole bit period of an overhead bit and low for payload bits.
- R4: In mode 2'b01, `ohgc_out` pulses high for one cycle, together with `oclk_out`, only for payload bits. It stays low for overhead bits.
- R5: In modes 2'b00 and 2'b01, `sof_out` is high during the bit period of frame position 0 and low otherwise.
- R6: In mode 2'b10, bits are packed first-received into `nib_out[3]`. A nibble is emitted, with a one-cycle `oclk_out` pulse, when the bit at a position with position mod 4 = 3 is taken. `oclk_out` stays low for the other three bits.
- R7: In mode 2'b10, `sof_out` is high for the nibble holding frame positions 0 to 3 and low for other nibbles.
- R8: In mode 2'b10, `ohgc_out` is high for a nibble if `cfg_e3`=1 and any of its four bits is overhead. `ohgc_out` is always low when `cfg_e3`=0.
- R9: A frame is 1536 bits. Overhead positions are 0 to 11 when `cfg_e3`=0 and 0 to 9 when `cfg_e3`=1. Without a sync marker, the position wraps from 1535 to 0.
- R10: Changes on `cfg_mode` and `cfg_e3` take effect only with the next bit that carries `in_fsync`. That bit is itself handled in the new setting.
- R11: A bit with `in_fsync` restarts the frame at position 0 at any time. A partly filled nibble is discarded, and the sync bit lands in `nib_out[3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Output form: 00 flag, 01 gapped clock, 10 nibble, 11 as 00 |
| cfg_e3 | input | 1 | Line type: 1 selects the E3 overhead map, 0 the DS3 map |
| in_bit | input | 1 | Received data bit |
| in_valid | input | 1 | One-cycle strobe per received bit, never on two cycles in a row |
| in_fsync | input | 1 | Marks the bit under the strobe as frame position 0 |
| ser_out | output | 1 | Serial data (low in nibble mode) |
| nib_out | output | 4 | Nibble data (zero in serial modes) |
| ohgc_out | output | 1 | Overhead flag or gapped payload clock, by mode |
| oclk_out | output | 1 | Output bit or nibble clock pulse |
| sof_out | output | 1 | Start-of-frame indicator |

## Verification
The hardest case to reach from the ports is a configuration change that arrives in the middle of a frame. From outside it looks exactly like an immediate switch unless the bench keeps feeding bits. The stimulus changes `cfg_mode` to nibble mode partway through a flag-mode frame and keeps checking serial behaviour until the next sync bit. A second directed case abandons a half-filled nibble with an early sync marker. It checks that none of the stale bits reach `nib_out`. The table pass runs past the frame length without a marker, so the position wrap and its start-of-frame pulse are covered too.

// File: rtl/fpo_pkg.sv
package fpo_pkg;

  typedef enum logic [1:0] {
    OM_FLAG = 2'b00,
    OM_GAP  = 2'b01,
    OM_NIB  = 2'b10,
    OM_RSV  = 2'b11
  } out_mode_e;

  // Reserved code falls back to the flag form.
  function automatic out_mode_e norm_mode(input logic [1:0] m);
    return (m == 2'b11) ? OM_FLAG : out_mode_e'(m);
  endfunction

  // Overhead occupies a prefix of the frame whose length depends on line type.
  function automatic logic pos_is_oh(input int unsigned pos, input logic e3,
                                     input int unsigned oh_ds3, input int unsigned oh_e3);
    return e3 ? (pos < oh_e3) : (pos < oh_ds3);
  endfunction

  // Slot 0 (first received) lands in nibble bit 3.
  function automatic logic [1:0] nib_lane(input logic [1:0] slot);
    return 2'd3 - slot;
  endfunction

endpackage

// File: rtl/fpo_frame_track.sv
module fpo_frame_track
  import fpo_pkg::*;
#(
  parameter int FRAME_BITS = 1536,
  localparam int POS_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_fsync,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_e3,
  output logic             take,
  output logic [POS_W-1:0] pos_now,
  output out_mode_e        mode_now,
  output logic             e3_now,
  output logic             synced
);

  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

  logic [POS_W-1:0] cnt_q;
  logic             synced_q;
  out_mode_e        mode_q;
  logic             e3_q;
  logic             sync_take;

  assign sync_take = in_valid && in_fsync;
  assign take      = in_valid && (synced_q || in_fsync);
  assign pos_now   = in_fsync ? '0 : cnt_q;
  assign mode_now  = in_fsync ? norm_mode(cfg_mode) : mode_q;
  assign e3_now    = in_fsync ? cfg_e3 : e3_q;
  assign synced    = synced_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      synced_q <= 1'b0;
      mode_q   <= OM_FLAG;
      e3_q     <= 1'b0;
    end else begin
      if (take) cnt_q <= (pos_now == LAST) ? '0 : pos_now + 1'b1;
      if (sync_take) begin
        synced_q <= 1'b1;
        mode_q   <= norm_mode(cfg_mode);
        e3_q     <= cfg_e3;
      end
    end
  end

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_take |=> ($stable(mode_q) && $stable(e3_q)));

  // R2 input contract: one strobe per two-cycle bit period
  valid_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> !in_valid);

endmodule

// File: rtl/fpo_nib_pack.sv
module fpo_nib_pack
  import fpo_pkg::*;
#(
  parameter int POS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             bit_in,
  input  logic [POS_W-1:0] pos_now,
  input  logic             oh_now,
  output logic             nib_done,
  output logic [3:0]       nib_word,
  output logic             nib_oh,
  output logic             nib_sof
);

  logic [3:0] acc_q, acc_nx;
  logic       oh_q, oh_nx;
  logic       sof_q, sof_nx;
  logic [1:0] slot;
  logic       first_slot;

  assign slot       = pos_now[1:0];
  assign first_slot = (slot == 2'd0);

  always_comb begin
    acc_nx = first_slot ? 4'b0000 : acc_q;
    acc_nx[nib_lane(slot)] = bit_in;
    oh_nx  = (first_slot ? 1'b0 : oh_q) | oh_now;
    sof_nx = first_slot ? (pos_now == '0) : sof_q;
  end

  assign nib_done = take && (slot == 2'd3);
  assign nib_word = acc_nx;
  assign nib_oh   = oh_nx;
  assign nib_sof  = sof_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      oh_q  <= 1'b0;
      sof_q <= 1'b0;
    end else if (take) begin
      acc_q <= acc_nx;
      oh_q  <= oh_nx;
      sof_q <= sof_nx;
    end
  end

  // R7
  nib_sof_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_done && nib_sof) |-> (pos_now == POS_W'(3)));

endmodule

// File: rtl/fpo_payload_out.sv
module fpo_payload_out
  import fpo_pkg::*;
#(
  parameter int FRAME_BITS = 1536,
  parameter int OH_DS3     = 12,
  parameter int OH_E3      = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_e3,
  input  logic       in_bit,
  input  logic       in_valid,
  input  logic       in_fsync,
  output logic       ser_out,
  output logic [3:0] nib_out,
  output logic       ohgc_out,
  output logic       oclk_out,
  output logic       sof_out
);

  localparam int POS_W = $clog2(FRAME_BITS);

  logic             take;
  logic [POS_W-1:0] pos_now;
  out_mode_e        mode_now;
  logic             e3_now;
  logic             synced;
  logic             oh_now;
  logic             nib_done;
  logic [3:0]       nib_word;
  logic             nib_oh;
  logic             nib_sof;

  logic       ser_q, ohgc_q, oclk_q, sof_q, gap_q;
  logic [3:0] nib_q;

  fpo_frame_track #(.FRAME_BITS(FRAME_BITS)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_fsync (in_fsync),
    .cfg_mode (cfg_mode),
    .cfg_e3   (cfg_e3),
    .take     (take),
    .pos_now  (pos_now),
    .mode_now (mode_now),
    .e3_now   (e3_now),
    .synced   (synced)
  );

  assign oh_now = pos_is_oh(32'(pos_now), e3_now, OH_DS3, OH_E3);

  fpo_nib_pack #(.POS_W(POS_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .bit_in   (in_bit),
    .pos_now  (pos_now),
    .oh_now   (oh_now),
    .nib_done (nib_done),
    .nib_word (nib_word),
    .nib_oh   (nib_oh),
    .nib_sof  (nib_sof)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ser_q  <= 1'b0;
      nib_q  <= '0;
      ohgc_q <= 1'b0;
      oclk_q <= 1'b0;
      sof_q  <= 1'b0;
      gap_q  <= 1'b0;
    end else begin
      oclk_q <= 1'b0;
      if (gap_q) ohgc_q <= 1'b0;
      if (take) begin
        unique case (mode_now)
          OM_NIB: begin
            ser_q <= 1'b0;
            gap_q <= 1'b0;
            if (nib_done) begin
              nib_q  <= nib_word;
              oclk_q <= 1'b1;
              sof_q  <= nib_sof;
              ohgc_q <= e3_now && nib_oh;
            end
          end
          OM_GAP: begin
            ser_q  <= in_bit;
            nib_q  <= '0;
            oclk_q <= 1'b1;
            sof_q  <= (pos_now == '0);
            ohgc_q <= !oh_now;
            gap_q  <= 1'b1;
          end
          default: begin
            ser_q  <= in_bit;
            nib_q  <= '0;
            oclk_q <= 1'b1;
            sof_q  <= (pos_now == '0);
            ohgc_q <= oh_now;
            gap_q  <= 1'b0;
          end
        endcase
      end
    end
  end

  assign ser_out  = ser_q;
  assign nib_out  = nib_q;
  assign ohgc_out = ohgc_q;
  assign oclk_out = oclk_q;
  assign sof_out  = sof_q;

  // R1
  presync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!synced && !in_fsync) |=> (!oclk_out && !ohgc_out && !sof_out));

  // R2
  oclk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oclk_out |=> !oclk_out);

  // R4
  gap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q && ohgc_out) |-> oclk_out);

  // R8
  ds3_nib_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode_now == OM_NIB && !e3_now) |=> !ohgc_out);

  // R5
  sof_with_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sof_out) |-> oclk_out);

endmodule

// File: tb/sim_fpo_payload_out.sv
module sim_fpo_payload_out;

  localparam int CLK_PERIOD = 10;
  localparam int FB   = 1536;
  localparam int OHD  = 12;
  localparam int OHE  = 10;
  localparam int NSCN = 7;

  // {cfg_mode, cfg_e3}
  localparam logic [2:0] SCN [NSCN] = '{
    3'b00_0, 3'b00_1, 3'b01_0, 3'b01_1, 3'b10_0, 3'b10_1, 3'b11_0
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic       cfg_e3 = 1'b0;
  logic       in_bit = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_fsync = 1'b0;
  logic       ser_out, ohgc_out, oclk_out, sof_out;
  logic [3:0] nib_out;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // bench reference state
  int         rpos = 0;
  bit         rsync = 1'b0;
  int         rmode = 0;
  bit         re3 = 1'b0;
  logic [3:0] rnib = '0;
  bit         roh = 1'b0;
  bit         rsof = 1'b0;
  logic [15:0] lfsr = 16'h1;

  // outputs seen right after the last taken bit
  logic       last_ser, last_oclk, last_ohgc, last_sof;
  logic [3:0] last_nib;

  fpo_payload_out u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_e3(cfg_e3),
    .in_bit(in_bit), .in_valid(in_valid), .in_fsync(in_fsync),
    .ser_out(ser_out), .nib_out(nib_out), .ohgc_out(ohgc_out),
    .oclk_out(oclk_out), .sof_out(sof_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d (pos %0d)", tag, what, act, exp, rpos);
    end
  endtask

  function automatic bit ref_oh(input int p, input bit e3);
    if (e3) return p < OHE;
    return p < OHD;
  endfunction

  function automatic bit next_data();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // one bit period: strobe cycle, then idle cycle
  task automatic drive_bit(input bit b, input bit fs);
    bit active, ovh;
    int slot;
    in_bit = b; in_valid = 1'b1; in_fsync = fs;
    if (fs) begin
      rsync = 1'b1; rpos = 0;
      rmode = (cfg_mode == 2'b11) ? 0 : int'(cfg_mode);
      re3 = cfg_e3;
    end
    active = rsync;
    ovh = ref_oh(rpos, re3);
    @(negedge clk);
    in_valid = 1'b0; in_fsync = 1'b0;
    last_ser = ser_out; last_oclk = oclk_out; last_ohgc = ohgc_out;
    last_sof = sof_out; last_nib = nib_out;
    if (!active) begin
      check("R1", "oclk presync", int'(oclk_out), 0);
      check("R1", "ohgc presync", int'(ohgc_out), 0);
      check("R1", "sof presync", int'(sof_out), 0);
      check("R1", "ser presync", int'(ser_out), 0);
    end else if (rmode == 2) begin
      slot = rpos % 4;
      if (slot == 0) begin rnib = '0; roh = 1'b0; rsof = (rpos == 0); end
      rnib[3-slot] = b;
      roh = roh | ovh;
      if (slot == 3) begin
        check("R6", "nibble", int'(nib_out), int'(rnib));
        check("R6", "oclk nibble", int'(oclk_out), 1);
        check("R7", "sof nibble", int'(sof_out), int'(rsof));
        check("R8", "ohgc nibble", int'(ohgc_out), int'(re3 && roh));
      end else begin
        check("R6", "oclk midnibble", int'(oclk_out), 0);
      end
    end else begin
      check("R2", "ser", int'(ser_out), int'(b));
      check("R2", "oclk high", int'(oclk_out), 1);
      check("R5", "sof", int'(sof_out), int'(rpos == 0));
      if (rmode == 1) check("R4", "gap clock", int'(ohgc_out), int'(!ovh));
      else            check("R3", "oh flag", int'(ohgc_out), int'(ovh));
    end
    if (active) rpos = (rpos == FB - 1) ? 0 : rpos + 1;
    @(negedge clk);
    check("R2", "oclk low", int'(oclk_out), 0);
    if (active && rmode == 1) check("R4", "gap low", int'(ohgc_out), 0);
    if (active && rmode == 0) check("R3", "oh hold", int'(ohgc_out), int'(ovh));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "ser reset", int'(ser_out), 0);
    check("R1", "nib reset", int'(nib_out), 0);
    check("R1", "ohgc reset", int'(ohgc_out), 0);
    check("R1", "oclk reset", int'(oclk_out), 0);
    check("R1", "sof reset", int'(sof_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: bits before any sync marker are ignored
    cfg_mode = 2'b01;
    for (int i = 0; i < 20; i++) drive_bit(next_data(), 1'b0);

    // table walk: each entry one full frame plus a wrap into the next
    for (int s = 0; s < NSCN; s++) begin
      cfg_mode = SCN[s][2:1];
      cfg_e3   = SCN[s][0];
      lfsr     = 16'hACE1 + 16'(s);
      drive_bit(next_data(), 1'b1);
      for (int i = 1; i < FB + 8; i++) begin
        drive_bit(next_data(), 1'b0);
        if (i == FB && rmode != 2) check("R9", "wrap sof", int'(last_sof), 1);
      end
    end

    // R10: change mid-frame is deferred to the next sync bit
    cfg_mode = 2'b00; cfg_e3 = 1'b0;
    drive_bit(1'b1, 1'b1);
    for (int i = 0; i < 30; i++) drive_bit(next_data(), 1'b0);
    cfg_mode = 2'b10; cfg_e3 = 1'b1;
    drive_bit(1'b1, 1'b0);
    check("R10", "still serial oclk", int'(last_oclk), 1);
    check("R10", "still serial ser", int'(last_ser), 1);
    check("R10", "still flag ohgc", int'(last_ohgc), 0);
    drive_bit(1'b0, 1'b1);
    check("R10", "nibble after sync", int'(last_oclk), 0);
    drive_bit(1'b1, 1'b0);
    drive_bit(1'b0, 1'b0);
    drive_bit(1'b1, 1'b0);
    check("R10", "first nibble", int'(last_nib), 5);
    check("R10", "e3 overhead nibble", int'(last_ohgc), 1);

    // R11: sync in the middle of a nibble drops the partial bits
    drive_bit(1'b1, 1'b0);
    drive_bit(1'b1, 1'b0);
    drive_bit(1'b1, 1'b1);
    drive_bit(1'b0, 1'b0);
    drive_bit(1'b0, 1'b0);
    drive_bit(1'b0, 1'b0);
    check("R11", "restart nibble", int'(last_nib), 8);
    check("R11", "restart sof", int'(last_sof), 1);
    for (int i = 0; i < 8; i++) drive_bit(1'b0, 1'b0);
    check("R9", "e3 partial overhead nibble", int'(last_ohgc), 1);
    for (int i = 0; i < 4; i++) drive_bit(1'b0, 1'b0);
    check("R9", "e3 payload nibble", int'(last_ohgc), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule